// File: doc/BRIEF.md
# Serial Configuration Memory Reader

This block fetches a configuration word from an external serial memory of 64 words of 16 bits, using the three-wire read protocol. Once reset is released, it produces the serial clock from the system clock. It shifts out a start bit, the two-bit read opcode and a six-bit word address of zero. It then samples the data that the memory returns. The burst runs without a break across the word boundary. It collects all sixteen bits of word 0, most significant first, and then the leading two or three bits of word 1. The bit count is `CFG_BITS`, either 18 or 19.

The memory's select line sits outside the block because it is wired to the system reset. Each release of reset therefore starts exactly one burst. When the last bit arrives, `cfg_done` pulses for one cycle and `cfg_word` carries the assembled word. The word then holds until the next reset. The output stream is a valid-only handshake: `cfg_done` is the valid, and there is no ready. Because the burst happens once and the word stays held, a configuration loader downstream cannot apply back-pressure and does not need to.

The high and low phase lengths of the serial clock are parameters counted in system-clock cycles. Sizing them for a 100 MHz system clock to at least 900 ns each meets the memory's minimum pulse widths and its 900 ns access time, because sampling happens at the end of the high phase.

Top module: `cfg_eeprom_reader`

## Requirements
- R1: While `rst_n` is low, and in the part of the first cycle after release that comes before the first rising edge of `clk`, `mem_sclk`, `mem_si` and `cfg_done` are 0. `cfg_word` is 0 while `rst_n` is low.
- R2: Every low phase of `mem_sclk` between a falling edge and the next rising edge lasts exactly `LOW_CYC` system cycles. Every high phase lasts exactly `HIGH_CYC` system cycles.
- R3: From the first rising edge of `clk` after reset release, `mem_si` carries the start bit 1 and then the opcode bits 1 and 0, one bit per serial clock. Each bit changes only while `mem_sclk` is low.
- R4: The next six serial clocks carry the word address with the most significant bit first, and all six bits are 0. `mem_si` stays 0 from then on.
- R5: A burst has exactly 9 + `CFG_BITS` rising edges of `mem_sclk`. After the last one, `mem_sclk` stays low until the next reset.
- R6: `mem_so` is sampled on the system-clock edge that ends each high phase, starting with the 10th serial clock. Values that `mem_so` shows early in the high phase, or after the falling edge, do not matter.
- R7: The first sampled bit, which is word 0 bit 15, lands in `cfg_word[CFG_BITS-1]`. Each later sample lands one position lower, so `cfg_word = {word0, leading CFG_BITS-16 bits of word1}`.
- R8: `cfg_done` is high for exactly one cycle per burst. In that cycle `cfg_word` already holds the full word, and the word stays unchanged afterwards.
- R9: If `rst_n` is asserted in the middle of a burst, the transfer stops. `mem_sclk` and `mem_si` go low, no `cfg_done` pulse appears, and a complete new burst runs after release.
- R10: With `CFG_BITS` = 19, the burst has 28 serial clocks and takes word 1 bits 15 to 13 as the three lowest bits of `cfg_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also acts as the memory select |
| mem_sclk | output | 1 | Serial clock to the memory |
| mem_si | output | 1 | Command and address bits to the memory |
| mem_so | input | 1 | Data returned by the memory |
| cfg_word | output | CFG_BITS | Assembled configuration word, held after the burst |
| cfg_done | output | 1 | One-cycle valid strobe for `cfg_word` |

## Verification
A wrong phase counter shows up within one serial clock as a high or low phase of the wrong length on `mem_sclk`. A wrong header register or bit index shows up at the memory within the first nine serial clocks as a wrong opcode or address bit. It also shows up at the end of the burst as a rising-edge count other than 9 + `CFG_BITS`. An off-by-one in sampling or packing only becomes visible when `cfg_done` fires, as a word that is shifted or corrupted. The memory model used in the bench drives stale data both before its access time and after the falling edge, so sampling too early or too late corrupts the word. The stimulus patterns are chosen so that neighbouring bits differ, which makes a shifted word differ from the expected one.

// File: rtl/cfgrd_pkg.sv
`timescale 1ns/1ps
package cfgrd_pkg;
  // sequencer states: waiting one cycle after reset, shifting, finished
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_END  = 2'd2
  } seq_state_t;

  localparam int          CMD_W    = 3;
  // start bit, then read opcode; leftmost bit is sent first
  localparam logic [CMD_W-1:0] READ_CMD = 3'b110;
endpackage

// File: rtl/cfgrd_phase_timer.sv
`timescale 1ns/1ps
module cfgrd_phase_timer #(
  parameter int HIGH_CYC = 90,
  parameter int LOW_CYC  = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tick
);
  localparam int MAX_CYC = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LOW_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (sclk) begin
      if (cnt == HI_LAST) begin
        sclk <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == LO_LAST) begin
        sclk <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // last cycle of a high phase: the sampling edge
  assign fall_tick = run && sclk && (cnt == HI_LAST);

  // independent run-length counters for the phase checks
  localparam int RUN_W = 16;
  logic [RUN_W-1:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= sclk ? hi_run + 1'b1 : '0;
      if (sclk)             lo_run <= '0;
      else if (~&lo_run)    lo_run <= lo_run + 1'b1;
    end
  end

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (int'(hi_run) == HIGH_CYC)); // R2
  AST_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (int'(lo_run) >= LOW_CYC)); // R2
endmodule

// File: rtl/cfgrd_bit_seq.sv
`timescale 1ns/1ps
module cfgrd_bit_seq
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int CFG_BITS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_tick,
  output logic run,
  output logic sdo,
  output logic sample_en,
  output logic last
);
  localparam int HDR_BITS = CMD_W + ADDR_W;
  localparam int NCLK     = HDR_BITS + CFG_BITS;
  localparam int IDX_W    = $clog2(NCLK + 1);
  localparam logic [HDR_BITS-1:0] HDR_INIT = {READ_CMD, {ADDR_W{1'b0}}};
  localparam logic [IDX_W-1:0]    IDX_LAST = IDX_W'(NCLK - 1);
  localparam logic [IDX_W-1:0]    IDX_DATA = IDX_W'(HDR_BITS);

  seq_state_t            state;
  logic [IDX_W-1:0]      bit_idx;
  logic [HDR_BITS-1:0]   hdr_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      bit_idx <= '0;
      hdr_sr  <= '0;
    end else begin
      unique case (state)
        ST_WAIT: begin
          state   <= ST_RUN;
          bit_idx <= '0;
          hdr_sr  <= HDR_INIT;
        end
        ST_RUN: begin
          if (fall_tick) begin
            hdr_sr <= {hdr_sr[HDR_BITS-2:0], 1'b0};
            if (bit_idx == IDX_LAST) state <= ST_END;
            else                     bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= ST_END;
      endcase
    end
  end

  assign run       = (state == ST_RUN);
  assign sdo       = run && hdr_sr[HDR_BITS-1];
  assign sample_en = fall_tick && run && (bit_idx >= IDX_DATA);
  assign last      = fall_tick && run && (bit_idx == IDX_LAST);

  AST_DATA_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bit_idx >= IDX_DATA) |-> !sdo); // R4
  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_END) |=> (state == ST_END)); // R8
endmodule

// File: rtl/cfgrd_capture.sv
`timescale 1ns/1ps
module cfgrd_capture #(
  parameter int CFG_BITS = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                last,
  input  logic                sdi,
  output logic [CFG_BITS-1:0] cfg_word,
  output logic                done
);
  localparam int SH_W = CFG_BITS - 1;

  logic [SH_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      cfg_word <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (sample_en) shreg    <= {shreg[SH_W-2:0], sdi};
      if (last)      cfg_word <= {shreg, sdi};
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cfg_word)); // R8
endmodule

// File: rtl/cfg_eeprom_reader.sv
`timescale 1ns/1ps
module cfg_eeprom_reader
  import cfgrd_pkg::*;
#(
  parameter int HIGH_CYC = 90,
  parameter int LOW_CYC  = 90,
  parameter int ADDR_W   = 6,
  parameter int CFG_BITS = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_sclk,
  output logic                mem_si,
  input  logic                mem_so,
  output logic [CFG_BITS-1:0] cfg_word,
  output logic                cfg_done
);
  localparam int NCLK  = CMD_W + ADDR_W + CFG_BITS;
  localparam int RCN_W = $clog2(NCLK + 1) + 1;

  logic run, fall_tick, sample_en, last;

  cfgrd_phase_timer #(.HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(mem_sclk), .fall_tick(fall_tick)
  );

  cfgrd_bit_seq #(.ADDR_W(ADDR_W), .CFG_BITS(CFG_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick),
    .run(run), .sdo(mem_si), .sample_en(sample_en), .last(last)
  );

  cfgrd_capture #(.CFG_BITS(CFG_BITS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .last(last),
    .sdi(mem_so), .cfg_word(cfg_word), .done(cfg_done)
  );

  // rising-edge counter on the serial clock, used by the burst checks
  logic              sclk_d;
  logic [RCN_W-1:0]  rise_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= mem_sclk;
      if (mem_sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (int'(rise_cnt) == NCLK)); // R5
  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rise_cnt) <= NCLK); // R5
  AST_SI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sclk && $past(mem_sclk)) |-> $stable(mem_si)); // R3
  AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> mem_sclk); // R6
endmodule

// File: tb/cfg_eeprom_reader_bench.sv
`timescale 1ns/1ps
// behavioral serial memory: stale data outside the valid window
module eeprom_resp #(
  parameter int ACC_NS = 25
) (
  input  logic        clk,
  input  logic        cs,
  input  logic        sclk,
  input  logic        din,
  input  logic        done,
  input  logic [15:0] w0,
  input  logic [15:0] w1,
  output logic        dout,
  output int          rises,
  output logic [8:0]  cmd,
  output int          hi_min,
  output int          hi_max,
  output int          lo_min,
  output int          lo_max,
  output int          dones
);
  int   run_len;
  logic prev;
  logic seen_fall;

  function automatic logic stream_bit(input int d);
    if (d < 16)      return w0[15 - d];
    else if (d < 32) return w1[31 - d];
    else             return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (!cs) begin
      rises = 0; cmd = '0; hi_min = 1000; hi_max = 0;
      lo_min = 1000; lo_max = 0; dones = 0; run_len = 0;
      prev = 1'b0; seen_fall = 1'b0;
    end else begin
      if (sclk && !prev) begin
        rises = rises + 1;
        if (rises <= 9) cmd = {cmd[7:0], din};
        if (seen_fall) begin
          if (run_len < lo_min) lo_min = run_len;
          if (run_len > lo_max) lo_max = run_len;
        end
        run_len = 1;
      end else if (!sclk && prev) begin
        if (run_len < hi_min) hi_min = run_len;
        if (run_len > hi_max) hi_max = run_len;
        seen_fall = 1'b1;
        run_len = 1;
      end else begin
        run_len = run_len + 1;
      end
      prev = sclk;
      if (done) dones = dones + 1;
    end
  end

  initial begin
    dout = 1'b0;
    forever begin
      @(posedge sclk);
      dout = ~dout;
      #(ACC_NS);
      if (cs && rises >= 10) dout = stream_bit(rises - 10);
      @(negedge sclk);
      dout = ~dout;
    end
  end
endmodule

module cfg_eeprom_reader_bench;
  localparam int HI = 4;
  localparam int LO = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] w0, w1;
  always #5 clk = ~clk;

  logic        sclk_a, si_a, so_a, done_a;
  logic [17:0] cfg_a;
  logic        sclk_b, si_b, so_b, done_b;
  logic [18:0] cfg_b;

  cfg_eeprom_reader #(.HIGH_CYC(HI), .LOW_CYC(LO), .CFG_BITS(18)) u_cfg_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .mem_sclk(sclk_a), .mem_si(si_a), .mem_so(so_a),
    .cfg_word(cfg_a), .cfg_done(done_a)
  );
  cfg_eeprom_reader #(.HIGH_CYC(HI), .LOW_CYC(LO), .CFG_BITS(19)) u_cfg_eeprom_reader_ext (
    .clk(clk), .rst_n(rst_n), .mem_sclk(sclk_b), .mem_si(si_b), .mem_so(so_b),
    .cfg_word(cfg_b), .cfg_done(done_b)
  );

  int rises_a, hmin_a, hmax_a, lmin_a, lmax_a, dones_a;
  int rises_b, hmin_b, hmax_b, lmin_b, lmax_b, dones_b;
  logic [8:0] cmd_a, cmd_b;

  eeprom_resp u_mem_a (.clk(clk), .cs(rst_n), .sclk(sclk_a), .din(si_a), .done(done_a),
    .w0(w0), .w1(w1), .dout(so_a), .rises(rises_a), .cmd(cmd_a), .hi_min(hmin_a),
    .hi_max(hmax_a), .lo_min(lmin_a), .lo_max(lmax_a), .dones(dones_a));
  eeprom_resp u_mem_b (.clk(clk), .cs(rst_n), .sclk(sclk_b), .din(si_b), .done(done_b),
    .w0(w0), .w1(w1), .dout(so_b), .rises(rises_b), .cmd(cmd_b), .hi_min(hmin_b),
    .hi_max(hmax_b), .lo_min(lmin_b), .lo_max(lmax_b), .dones(dones_b));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [17:0] wd_a;
  logic [18:0] wd_b;

  always @(negedge clk) begin
    if (done_a) wd_a = cfg_a;
    if (done_b) wd_b = cfg_b;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; w0 = '0; w1 = '0;
    repeat (4) @(negedge clk);
    chk(cfg_a == '0 && cfg_b == '0, "R1 word", {cfg_a, cfg_b}, 0);
    chk(!sclk_a && !si_a && !done_a && !sclk_b && !si_b && !done_b, "R1 pins",
        {sclk_a, si_a, done_a, sclk_b, si_b, done_b}, 0);
    for (int t = 0; t < 20; t++) begin
      w0 = 16'(16'h1 << (t % 16)) ^ 16'(t * 16'h02d3);
      w1 = {3'(t), 13'(t * 37 + 5)};
      if (t == 18) begin w0 = 16'hffff; w1 = 16'hffff; end
      if (t == 19) begin w0 = 16'h0000; w1 = 16'h0000; end
      wd_a = '0; wd_b = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!done_a && !done_b && !sclk_a && !si_b, "R1 in reset", {done_a, done_b, sclk_a, si_b}, 0);
      rst_n = 1'b1;
      #1;
      chk(!si_a && !sclk_a && !si_b, "R1 wait cycle", {si_a, sclk_a, si_b}, 0);
      @(negedge clk);
      chk(si_a && !sclk_a && si_b, "R3 start bit", {si_a, sclk_a, si_b}, 3'b101);
      if (t == 5) begin
        repeat (100) @(negedge clk);
        chk(dones_a == 0 && dones_b == 0, "R9 mid burst", dones_a + dones_b, 0);
        rst_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          chk(!done_a && !done_b && !sclk_a && !sclk_b && !si_a && !si_b, "R9 abort",
              {done_a, done_b, sclk_a, sclk_b, si_a, si_b}, 0);
        end
        rst_n = 1'b1;
      end
      repeat (260) @(negedge clk);
      chk(dones_a == 1, "R8 one done base", dones_a, 1);
      chk(dones_b == 1, "R8 one done ext", dones_b, 1);
      chk(wd_a == {w0, w1[15:14]}, "R7 R6 word at done", wd_a, {w0, w1[15:14]});
      chk(wd_b == {w0, w1[15:13]}, "R10 R6 word at done", wd_b, {w0, w1[15:13]});
      chk(cfg_a == {w0, w1[15:14]}, "R8 word held", cfg_a, {w0, w1[15:14]});
      chk(cfg_b == {w0, w1[15:13]}, "R8 word held ext", cfg_b, {w0, w1[15:13]});
      chk(rises_a == 27 && !sclk_a, "R5 edges base", rises_a, 27);
      chk(rises_b == 28 && !sclk_b, "R10 R5 edges ext", rises_b, 28);
      chk(cmd_a[8:6] == 3'b110 && cmd_b[8:6] == 3'b110, "R3 opcode", {cmd_a[8:6], cmd_b[8:6]}, 6'o66);
      chk(cmd_a[5:0] == 0 && cmd_b[5:0] == 0 && !si_a && !si_b, "R4 address", {cmd_a[5:0], cmd_b[5:0]}, 0);
      chk(hmin_a == HI && hmax_a == HI && hmin_b == HI && hmax_b == HI, "R2 high",
          {8'(hmin_a), 8'(hmax_a)}, {8'(HI), 8'(HI)});
      chk(lmin_a == LO && lmax_a == LO && lmin_b == LO && lmax_b == LO, "R2 low",
          {8'(lmin_a), 8'(lmax_a)}, {8'(LO), 8'(LO)});
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule